// File: doc/BRIEF.md
# Serial Port Register Interface

This block is the register front end of one asynchronous serial channel on a 16-bit memory-mapped bus. It answers four word-aligned ports in an 8-byte window: receive status, receive data, transmit status and transmit data. Each direction has a status register with a ready flag and a software-writable interrupt enable. When a direction becomes ready while its enable is set, the block latches an interrupt request. That request stays up until an external interrupt controller pulses the matching clear input, or until software drops the enable.

A small transmitter and receiver sit behind the registers. Both run from a 16x oversample tick and use a fixed frame: one start bit, 8 data bits sent LSB first, no parity and 2 stop bits. The transmitter has a one-byte holding buffer in front of its shifter. Its ready flag and its request fire at the moment the buffer hands its byte to the shifter, not when the frame finishes. A break bit in the transmit status register holds the serial output low for as long as software leaves it set.

Top module: `serial_port_regs`

## Requirements
- R1: Ports decode at BASE+0 (receive status), BASE+2 (receive data), BASE+4 (transmit status) and BASE+6 (transmit data), with BASE = 0x1F40 by default. A read outside the 8-byte window returns 0x0000, and a write outside it changes nothing.
- R2: Bit 6 of each status register is that direction's interrupt enable. It is 0 after reset, a write to the status port sets it from write-data bit 6, and it reads back in bit 6.
- R3: Bit 7 of each status register is that direction's ready flag, whatever the enable holds. After reset, receive ready is 0 and transmit ready is 1, so receive status reads 0x0000 and transmit status reads 0x0080.
- R4: A word read of receive data returns {8'h00, byte}. A byte read at an even address returns that word's low byte in bits 7:0. A byte read at an odd address returns the word's high byte in bits 7:0, which is 0x00 for all four ports. A byte write to an odd address changes no status bit and loads no transmit byte.
- R5: rx_irq sets at the same clock edge that receive ready rises, and only if the receive enable is 1 at that edge. It then holds until it is cleared.
- R6: tx_irq sets, if the transmit enable is 1, at the edge where the holding buffer passes its byte to the shifter and transmit ready rises. At that point the serial output is still in the start bit.
- R7: A rx_irq_clr or tx_irq_clr pulse drops the matching request at the next edge and wins over a set in the same cycle. Writing 0 to an enable bit also drops that direction's request.
- R8: Any read of the receive data port, word or byte, clears receive ready. A write to the transmit data port clears transmit ready until the buffer passes its byte to the shifter.
- R9: Bit 0 of transmit status is the break control. It is 0 after reset and reads back. While it is 1, ser_tx is low from the cycle after the write.
- R10: ser_tx idles high. A frame is a low start bit, then 8 data bits LSB first, then 2 high stop bits, and each bit lasts 16 baud ticks.
- R11: The receiver checks the start bit 8 ticks after it first sees the line low, then samples each data bit 16 ticks apart. A low pulse shorter than half a bit is rejected and sets no ready.
- R12: A received frame whose stop bit samples low is discarded. Receive ready and the receive data are left unchanged.
- R13: A byte written while a frame is shifting waits in the holding buffer. Transmit ready stays 0 until the current frame's last stop bit ends, and then the handoff sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wr | input | 1 | Write strobe; takes effect at the clock edge |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is active |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| ser_rx | input | 1 | Serial input, asynchronous |
| ser_tx | output | 1 | Serial output |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq_clr | input | 1 | Clear pulse for the receive request |
| tx_irq_clr | input | 1 | Clear pulse for the transmit request |

## Verification
Read data is combinational, so the bench samples a status or data word in the same cycle it raises the read strobe. A write, a read side effect or a clear pulse shows up at the ports one cycle later. A byte written to an idle transmitter leaves transmit ready at 0 for exactly one cycle. In the next cycle ready, tx_irq and the low start bit appear together, and the bench samples that cycle directly. For serial timing the bench counts baud ticks itself from the first low cycle it sees, and it samples each transmitted bit 8 ticks into its 16-tick slot. This keeps the sampling point safe even when the start of the frame is seen one cycle late. For received frames the bench polls receive status, with a bounded wait, until ready appears, because the two-stage input synchronizer shifts the end of the frame by two cycles.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam logic [1:0] PORT_RX_STAT = 2'd0;
  localparam logic [1:0] PORT_RX_DATA = 2'd1;
  localparam logic [1:0] PORT_TX_STAT = 2'd2;
  localparam logic [1:0] PORT_TX_DATA = 2'd3;

  localparam int BIT_BRK = 0;
  localparam int BIT_IE  = 6;
  localparam int BIT_RDY = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_DATA,
    SEL_TX_STAT,
    SEL_TX_DATA
  } port_sel_e;

  function automatic int frame_bits(input int data_bits, input int stop_bits);
    return 1 + data_bits + stop_bits;
  endfunction

  function automatic logic [15:0] status_word(input logic rdy, input logic ie,
                                              input logic brk);
    logic [15:0] s;
    s          = '0;
    s[BIT_RDY] = rdy;
    s[BIT_IE]  = ie;
    s[BIT_BRK] = brk;
    return s;
  endfunction

  function automatic logic [15:0] lane_pick(input logic [15:0] w, input logic byte_acc,
                                            input logic odd);
    if (!byte_acc) return w;
    if (odd) return {8'h00, w[15:8]};
    return {8'h00, w[7:0]};
  endfunction

endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import sp_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1F40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              byte_acc,
  output port_sel_e         sel,
  output logic              odd,
  output logic              rd_rx_data,
  output logic              wr_rx_stat,
  output logic              wr_tx_stat,
  output logic              wr_tx_data
);

  logic in_window;
  logic low_lane;

  assign in_window = (addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign odd       = addr[0];
  assign low_lane  = !(byte_acc && addr[0]);

  always_comb begin
    sel = SEL_NONE;
    if (in_window) begin
      case (addr[2:1])
        PORT_RX_STAT: sel = SEL_RX_STAT;
        PORT_RX_DATA: sel = SEL_RX_DATA;
        PORT_TX_STAT: sel = SEL_TX_STAT;
        default:      sel = SEL_TX_DATA;
      endcase
    end
  end

  assign rd_rx_data = rd && (sel == SEL_RX_DATA);
  assign wr_rx_stat = wr && low_lane && (sel == SEL_RX_STAT);
  assign wr_tx_stat = wr && low_lane && (sel == SEL_TX_STAT);
  assign wr_tx_data = wr && low_lane && (sel == SEL_TX_DATA);

endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 2,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] din,
  output logic                 handoff,
  output logic                 line
);

  localparam int FL = frame_bits(DATA_BITS, STOP_BITS);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int NW = $clog2(FL);

  logic [DATA_BITS-1:0] hold_q;
  logic                 hold_full;
  logic [FL-1:0]        sh_q;
  logic [CW-1:0]        tcnt;
  logic [NW-1:0]        left;
  logic                 active;

  assign handoff = hold_full && !active;
  assign line    = active ? sh_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (load) begin
      hold_q    <= din;
      hold_full <= 1'b1;
    end else if (handoff) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tcnt   <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (handoff) begin
      sh_q   <= {{STOP_BITS{1'b1}}, hold_q, 1'b0};
      tcnt   <= '0;
      left   <= NW'(FL - 1);
      active <= 1'b1;
    end else if (active && tick) begin
      if (tcnt == CW'(OVERSAMPLE - 1)) begin
        tcnt <= '0;
        sh_q <= {1'b1, sh_q[FL-1:1]};
        if (left == '0) active <= 1'b0;
        else            left   <= left - 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_in,
  output logic [DATA_BITS-1:0] data,
  output logic                 done_evt
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  rx_state_e            st;
  logic [1:0]           sync_q;
  logic                 rx_s;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 slot_end;

  assign rx_s     = sync_q[1];
  assign slot_end = tick && (cnt == CW'(OVERSAMPLE - 1));
  assign done_evt = (st == RX_STOP) && slot_end && rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      data  <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CW'(OVERSAMPLE / 2 - 1)) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (slot_end) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DATA_BITS-1:1]};
            if (bitn == BW'(DATA_BITS - 1)) st <= RX_STOP;
            else                            bitn <= bitn + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (slot_end) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (rx_s) data <= shreg;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sp_irq_chan.sv
module sp_irq_chan #(
  parameter bit READY_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_wr,
  input  logic ie_din,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic irq_clr,
  output logic ie,
  output logic ready,
  output logic req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      ready <= READY_INIT;
      req   <= 1'b0;
    end else begin
      if (ie_wr) ie <= ie_din;
      if (set_evt)      ready <= 1'b1;
      else if (clr_evt) ready <= 1'b0;
      if (irq_clr || (ie_wr && !ie_din)) req <= 1'b0;
      else if (set_evt && ie)            req <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h1F40,
  parameter int                DATA_BITS  = 8,
  parameter int                STOP_BITS  = 2,
  parameter int                OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_byte,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              baud_tick,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              rx_irq,
  output logic              tx_irq,
  input  logic              rx_irq_clr,
  input  logic              tx_irq_clr
);

  localparam int NCH = 2;

  port_sel_e            sel;
  logic                 odd;
  logic                 rd_rx_data;
  logic                 wr_rx_stat;
  logic                 wr_tx_stat;
  logic                 wr_tx_data;
  logic                 brk_q;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 rx_done_evt;
  logic                 tx_handoff;
  logic                 tx_empty_evt;
  logic                 tx_line;
  logic                 rx_ready, tx_ready, rx_ie, tx_ie;
  logic [NCH-1:0]       ch_ie_wr, ch_set, ch_clr, ch_irq_clr, ch_ie, ch_ready, ch_req;
  logic [15:0]          word_sel;

  sp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .byte_acc(bus_byte),
    .sel(sel), .odd(odd), .rd_rx_data(rd_rx_data), .wr_rx_stat(wr_rx_stat),
    .wr_tx_stat(wr_tx_stat), .wr_tx_data(wr_tx_data)
  );

  sp_tx #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS), .OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(wr_tx_data),
    .din(bus_wdata[DATA_BITS-1:0]), .handoff(tx_handoff), .line(tx_line)
  );

  sp_rx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_in(ser_rx),
    .data(rx_byte), .done_evt(rx_done_evt)
  );

  // a same-cycle write refills the buffer, so ready does not rise
  assign tx_empty_evt = tx_handoff && !wr_tx_data;

  // channel 0 = receive, channel 1 = transmit
  assign ch_ie_wr   = {wr_tx_stat, wr_rx_stat};
  assign ch_set     = {tx_empty_evt, rx_done_evt};
  assign ch_clr     = {wr_tx_data, rd_rx_data};
  assign ch_irq_clr = {tx_irq_clr, rx_irq_clr};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sp_irq_chan #(.READY_INIT(g == 1 ? 1'b1 : 1'b0)) u_chan (
      .clk(clk), .rst_n(rst_n), .ie_wr(ch_ie_wr[g]), .ie_din(bus_wdata[BIT_IE]),
      .set_evt(ch_set[g]), .clr_evt(ch_clr[g]), .irq_clr(ch_irq_clr[g]),
      .ie(ch_ie[g]), .ready(ch_ready[g]), .req(ch_req[g])
    );
  end

  assign rx_ready = ch_ready[0];
  assign tx_ready = ch_ready[1];
  assign rx_ie    = ch_ie[0];
  assign tx_ie    = ch_ie[1];
  assign rx_irq   = ch_req[0];
  assign tx_irq   = ch_req[1];

  always_ff @(posedge clk) begin
    if (!rst_n)          brk_q <= 1'b0;
    else if (wr_tx_stat) brk_q <= bus_wdata[BIT_BRK];
  end

  always_comb begin
    case (sel)
      SEL_RX_STAT: word_sel = status_word(rx_ready, rx_ie, 1'b0);
      SEL_RX_DATA: word_sel = 16'(rx_byte);
      SEL_TX_STAT: word_sel = status_word(tx_ready, tx_ie, brk_q);
      default:     word_sel = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? lane_pick(word_sel, bus_byte, odd) : 16'h0000;
  assign ser_tx    = tx_line && !brk_q;

endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_done_evt,
  input logic tx_empty_evt,
  input logic rx_ready,
  input logic tx_ready,
  input logic rx_ie,
  input logic tx_ie,
  input logic rx_irq,
  input logic tx_irq,
  input logic rx_irq_clr,
  input logic tx_irq_clr,
  input logic ser_tx,
  input logic rd_rx_data,
  input logic wr_rx_stat,
  input logic wr_tx_stat,
  input logic wr_tx_data
);

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_rx_data, wr_rx_stat, wr_tx_stat, wr_tx_data}));

  assert_rx_req_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !$past(rx_irq)) |-> ($past(rx_ie) && $past(rx_done_evt)));

  assert_tx_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !$past(tx_irq)) |-> ($past(tx_ie) && $past(tx_empty_evt)));

  assert_rx_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_clr |=> !rx_irq);

  assert_tx_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_clr |=> !tx_irq);

  assert_rx_ready_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !$past(rx_ready)) |-> $past(rx_done_evt));

  assert_start_after_handoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |=> !ser_tx);

  assert_busy_after_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx_data |=> !tx_ready);

endmodule

bind serial_port_regs sp_checker u_sp_checker (
  .clk(clk), .rst_n(rst_n), .rx_done_evt(rx_done_evt), .tx_empty_evt(tx_empty_evt),
  .rx_ready(rx_ready), .tx_ready(tx_ready), .rx_ie(rx_ie), .tx_ie(tx_ie),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_irq_clr(rx_irq_clr), .tx_irq_clr(tx_irq_clr),
  .ser_tx(ser_tx), .rd_rx_data(rd_rx_data), .wr_rx_stat(wr_rx_stat),
  .wr_tx_stat(wr_tx_stat), .wr_tx_data(wr_tx_data)
);

// File: tb/test_serial_port_regs.sv
`timescale 1ns/1ps
module test_serial_port_regs;

  localparam logic [15:0] BASE = 16'h1F40;
  localparam logic [15:0] A_RXS = BASE + 16'd0;
  localparam logic [15:0] A_RXD = BASE + 16'd2;
  localparam logic [15:0] A_TXS = BASE + 16'd4;
  localparam logic [15:0] A_TXD = BASE + 16'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, bytea = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic        ser_rx, ser_tx, rx_irq, tx_irq;
  logic        rx_clr = 1'b0, tx_clr = 1'b0;
  logic        loop_en = 1'b0, drv_rx = 1'b1;
  int          tdiv = 1, tcnt = 0, cyc = 0;
  int          vectors = 0, fails = 0;

  assign ser_rx = loop_en ? ser_tx : drv_rx;

  serial_port_regs i_serial_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_byte(bytea),
    .bus_wdata(wdata), .bus_rdata(rdata), .baud_tick(tick), .ser_rx(ser_rx),
    .ser_tx(ser_tx), .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_irq_clr(rx_clr),
    .tx_irq_clr(tx_clr)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [15:0] stat(input int rdy, input int ie, input int brk);
    return 16'(rdy * 128 + ie * 64 + brk);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic b);
    addr = a; wdata = d; bytea = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic b, output logic [15:0] q);
    addr = a; bytea = b; rd = 1'b1;
    #1 q = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_clr(input bit tx_side);
    if (tx_side) tx_clr = 1'b1; else rx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0; rx_clr = 1'b0;
  endtask

  task automatic hold_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
    #1;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stopv);
    drv_rx = 1'b0; hold_ticks(16);
    for (int i = 0; i < 8; i++) begin drv_rx = d[i]; hold_ticks(16); end
    drv_rx = stopv; hold_ticks(16);
    drv_rx = 1'b1; hold_ticks(32);
    @(negedge clk);
  endtask

  task automatic grab_tx(output logic [10:0] bits);
    int guard = 0;
    int n = 0;
    do begin @(posedge clk); #1; guard++; end while (ser_tx && guard < 3000);
    for (int k = 0; k < 11; k++) begin
      while (n < 16 * k + 8) begin
        @(posedge clk);
        if (tick) n++;
      end
      #1 bits[k] = ser_tx;
    end
  endtask

  task automatic wait_rx_ready(output logic [15:0] q);
    int guard = 0;
    do begin bus_rd(A_RXS, 1'b0, q); guard++; end while (!q[7] && guard < 100);
  endtask

  task automatic loop_byte(input logic [7:0] b, input int ie);
    logic [10:0] fr;
    logic [15:0] q;
    bus_wr(A_RXS, stat(0, ie, 0), 1'b0);
    bus_wr(A_TXD, {8'h00, b}, 1'b0);
    fork
      grab_tx(fr);
      begin
        bus_rd(A_TXS, 1'b0, q); chk("R8 tx ready low after data write", q, stat(0, 1, 0));
        chk("R6 tx_irq at handoff", {15'd0, tx_irq}, 16'd1);
        chk("R6 line in start bit at request", {15'd0, ser_tx}, 16'd0);
        bus_rd(A_TXS, 1'b0, q); chk("R3 tx ready back", q, stat(1, 1, 0));
        pulse_clr(1'b1);
        chk("R7 tx_irq cleared", {15'd0, tx_irq}, 16'd0);
      end
    join
    chk("R10 frame bits", {5'd0, fr}, {5'd0, 2'b11, b, 1'b0});
    wait_rx_ready(q);
    chk("R3 rx status ready", q, stat(1, ie, 0));
    chk("R5 rx_irq follows enable", {15'd0, rx_irq}, 16'(ie));
    bus_rd(A_RXD, 1'b0, q); chk("R11 rx word data", q, {8'h00, b});
    bus_rd(A_RXS, 1'b0, q); chk("R8 rx ready cleared by read", q, stat(0, ie, 0));
    if (ie == 1) begin
      chk("R5 request holds past data read", {15'd0, rx_irq}, 16'd1);
      pulse_clr(1'b0);
      chk("R7 rx_irq cleared", {15'd0, rx_irq}, 16'd0);
    end
    repeat (24 * tdiv) @(negedge clk);
  endtask

  initial begin
    logic [15:0] q;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_rd(A_RXS, 1'b0, q); chk("R3 rx status reset", q, 16'h0000);
    bus_rd(A_TXS, 1'b0, q); chk("R3 tx status reset", q, 16'h0080);
    bus_rd(A_RXD, 1'b0, q); chk("R4 rx data reset", q, 16'h0000);
    chk("R10 line idle high", {15'd0, ser_tx}, 16'd1);
    chk("R5 irqs low after reset", {14'd0, rx_irq, tx_irq}, 16'd0);

    // window decode
    bus_rd(BASE + 16'd8, 1'b0, q); chk("R1 read above window", q, 16'h0000);
    bus_rd(BASE - 16'd2, 1'b0, q); chk("R1 read below window", q, 16'h0000);
    bus_wr(BASE + 16'd8, 16'h0041, 1'b0);
    bus_wr(BASE - 16'd4, 16'h0041, 1'b0);
    bus_rd(A_RXS, 1'b0, q); chk("R1 outside write ignored rx", q, 16'h0000);
    bus_rd(A_TXS, 1'b0, q); chk("R1 outside write ignored tx", q, 16'h0080);
    chk("R1 outside write no break", {15'd0, ser_tx}, 16'd1);

    // enable readback
    bus_wr(A_RXS, 16'h0040, 1'b0);
    bus_wr(A_TXS, 16'h0040, 1'b0);
    bus_rd(A_RXS, 1'b0, q); chk("R2 rx enable readback", q, 16'h0040);
    bus_rd(A_TXS, 1'b0, q); chk("R2 tx enable readback", q, 16'h00C0);
    bus_wr(A_RXS, 16'h0000, 1'b0);
    bus_rd(A_RXS, 1'b0, q); chk("R2 rx enable cleared", q, 16'h0000);

    // byte lanes
    bus_rd(A_TXS + 16'd1, 1'b1, q); chk("R4 odd byte read", q, 16'h0000);
    bus_rd(A_TXS, 1'b1, q); chk("R4 even byte read", q, 16'h00C0);
    bus_wr(A_TXS + 16'd1, 16'h0101, 1'b1);
    bus_rd(A_TXS, 1'b0, q); chk("R4 odd byte write ignored", q, 16'h00C0);
    chk("R4 odd byte write no break", {15'd0, ser_tx}, 16'd1);
    bus_wr(A_TXD + 16'd1, 16'h5555, 1'b1);
    bus_rd(A_TXS, 1'b0, q); chk("R4 odd data byte not loaded", q, 16'h00C0);

    // break control
    bus_wr(A_TXS, 16'h0001, 1'b0);
    chk("R9 break forces low", {15'd0, ser_tx}, 16'd0);
    bus_rd(A_TXS, 1'b0, q); chk("R9 break readback", q, 16'h0081);
    repeat (40) @(negedge clk);
    chk("R9 break held", {15'd0, ser_tx}, 16'd0);
    bus_wr(A_TXS, 16'h0040, 1'b0);
    chk("R9 break released", {15'd0, ser_tx}, 16'd1);

    // direct receive: false start, bad stop, good frame, byte reads
    loop_en = 1'b0;
    bus_wr(A_RXS, 16'h0040, 1'b0);
    drv_rx = 1'b0; hold_ticks(4); drv_rx = 1'b1; hold_ticks(220); @(negedge clk);
    bus_rd(A_RXS, 1'b0, q); chk("R11 short start rejected", q, 16'h0040);
    send_rx(8'h3C, 1'b0);
    bus_rd(A_RXS, 1'b0, q); chk("R12 low stop discarded", q, 16'h0040);
    bus_rd(A_RXD, 1'b0, q); chk("R12 data unchanged", q, 16'h0000);
    chk("R12 no request", {15'd0, rx_irq}, 16'd0);
    send_rx(8'hC3, 1'b1);
    bus_rd(A_RXS, 1'b0, q); chk("R11 good frame ready", q, 16'h00C0);
    chk("R5 rx request raised", {15'd0, rx_irq}, 16'd1);
    bus_wr(A_RXS, 16'h0000, 1'b0);
    chk("R7 enable drop clears request", {15'd0, rx_irq}, 16'd0);
    bus_rd(A_RXS + 16'd1, 1'b1, q); chk("R4 rx status high byte", q, 16'h0000);
    bus_rd(A_RXD, 1'b1, q); chk("R4 rx data low byte", q, 16'h00C3);
    bus_rd(A_RXS, 1'b0, q); chk("R8 byte read clears ready", q, 16'h0000);
    send_rx(8'h96, 1'b1);
    bus_rd(A_RXD + 16'd1, 1'b1, q); chk("R4 rx data high byte", q, 16'h0000);
    bus_rd(A_RXS, 1'b0, q); chk("R8 high byte read clears ready", q, 16'h0000);

    // back-to-back transmit
    bus_wr(A_TXD, 16'h00AA, 1'b0);
    repeat (2) @(negedge clk);
    pulse_clr(1'b1);
    bus_wr(A_TXD, 16'h0055, 1'b0);
    n = 0;
    do begin bus_rd(A_TXS, 1'b0, q); n++; end while (!q[7] && n < 400);
    vectors++;
    if (n < 150 || n > 185) begin
      fails++;
      $display("FAIL R13 ready wait: got %0d cycles exp 150..185", n);
    end
    chk("R13 request at second handoff", {15'd0, tx_irq}, 16'd1);
    pulse_clr(1'b1);
    repeat (200) @(negedge clk);

    // loopback sweep, all byte values
    loop_en = 1'b1;
    for (int b = 0; b < 256; b++) loop_byte(8'(b), b % 2);
    tdiv = 3;
    repeat (4) @(negedge clk);
    loop_byte(8'h5A, 1);
    loop_byte(8'hA5, 0);
    loop_byte(8'h01, 1);
    loop_byte(8'h80, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule